// File: doc/BRIEF.md
# Range Translation Cache

This block is a small, fully associative cache of range translations. It sits beside the second-level TLB and is queried whenever the first-level data TLB misses. Each entry describes one contiguous run of virtual pages that maps onto a contiguous run of physical pages. An entry holds a lower bound page, an upper bound page, a signed page displacement and one protection field shared by every page in the run. A lookup compares the virtual page number against the two bounds of every entry in parallel. On a hit, the block adds the entry's displacement to the page number to build an ordinary 4KB frame number. That frame number, together with the entry's protection, goes out as a refill for the first-level TLB.

Pages are 4KB and addresses are 48 bits wide, so page numbers carry bits 47..12 (36 bits). Lookups enter on a valid/ready port and results leave on a registered valid/ready port. A result that the consumer has not taken holds the lookup port off: `lkp_ready` is low exactly while `res_valid` is high and `res_ready` is low. New ranges arrive on a valid/ready insert port, which is ready in every cycle except one in which `inv_all` is high. `inv_all` is a plain control pin that empties the whole cache in one cycle.

Top module: `range_tlb`

## Requirements
- R1: After reset `res_valid` is 0 and every entry is empty, so the first lookup returns a miss.
- R2: An entry hits when it is valid and base <= vpn <= limit (both bounds inclusive). A page just below the base or just above the limit misses.
- R3: On a hit, `res_pfn` = (vpn + offset) mod 2^36, where the offset is 36-bit two's complement, and `res_prot` is the entry's protection. On a miss, `res_hit`, `res_pfn` and `res_prot` are all 0.
- R4: When several entries hit, the entry with the lowest index supplies the result.
- R5: An insert whose limit is below its base is accepted but changes no entry and does not move the replacement pointer.
- R6: A legal insert writes the lowest-indexed empty entry.
- R7: When every entry is full, a legal insert overwrites the entry named by a replacement pointer. The pointer resets to 0, advances by one after each such overwrite, wraps from the last entry to 0, and is not reset by `inv_all`.
- R8: `inv_all` empties every entry at the next clock edge. An insert offered in the same cycle is not accepted (`ins_ready` = 0). A lookup accepted in the same cycle sees the contents from before the clear.
- R9: The result of an accepted lookup appears on the `res_*` outputs at the next clock edge. While `res_valid` = 1 and `res_ready` = 0, the result stays stable and `lkp_ready` = 0.
- R10: A lookup accepted in the same cycle as an insert sees the table from before that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request accepted when high with lkp_valid |
| lkp_vpn | input | 36 | Virtual page number to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Lookup hit a range |
| res_pfn | output | 36 | Synthesized physical frame number for the L1 refill |
| res_prot | output | 4 | Protection of the hit range |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert accepted when high with ins_valid |
| ins_base | input | 36 | First page of the new range |
| ins_limit | input | 36 | Last page of the new range (inclusive) |
| ins_offset | input | 36 | Two's-complement page displacement |
| ins_prot | input | 4 | Protection of the new range |
| inv_all | input | 1 | Empty every entry |

## Verification
Every cycle, the assertions check that the result holds while it is back-pressured, and that an accepted lookup always produces a result on the next edge. They also check that the grant is a single entry and the lowest-indexed match, and that the frame number equals the page plus the selected displacement. Further checks cover the occupancy: a legal fill adds exactly one entry, a reversed range changes nothing, a clear empties the table, and overwrites happen only when the table is full. Only the bench's scenarios can show the end-to-end behaviour. That covers which physical entry a fill or an overwrite landed in, seen through overlap priority and evicted ranges. It also covers inclusive bound edges, wrap-around of negative displacements, and the ordering of a lookup against an insert or clear in the same cycle.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  localparam int unsigned RTLB_VPN_W   = 36;
  localparam int unsigned RTLB_PROT_W  = 4;
  localparam int unsigned RTLB_ENTRIES = 32;

  // what the allocator decided for the insert offered this cycle
  typedef enum logic [1:0] {
    ALLOC_IDLE   = 2'd0,
    ALLOC_FILL   = 2'd1,
    ALLOC_EVICT  = 2'd2,
    ALLOC_REJECT = 2'd3
  } alloc_act_e;
endpackage

// File: rtl/rtlb_store.sv
// Entry storage plus the per-entry bound comparators.
module rtlb_store #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 36,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [VW-1:0] wr_base,
  input  logic [VW-1:0] wr_limit,
  input  logic [VW-1:0] wr_offset,
  input  logic [PW-1:0] wr_prot,
  input  logic [VW-1:0] look_vpn,
  output logic [N-1:0]  valid_o,
  output logic [N-1:0]  match_o,
  output logic [VW-1:0] off_o  [N],
  output logic [PW-1:0] prot_o [N]
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic          v_q;
    logic [VW-1:0] lo_q;
    logic [VW-1:0] hi_q;
    logic [VW-1:0] off_q;
    logic [PW-1:0] prot_q;
    logic          sel;
    logic          ge_lo;
    logic          le_hi;

    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       v_q <= 1'b0;
      else if (clr_all) v_q <= 1'b0;
      else if (sel)     v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        lo_q   <= wr_base;
        hi_q   <= wr_limit;
        off_q  <= wr_offset;
        prot_q <= wr_prot;
      end
    end

    // both bounds are compared in every entry, in parallel
    assign ge_lo      = (look_vpn >= lo_q);
    assign le_hi      = (look_vpn <= hi_q);
    assign match_o[g] = v_q && ge_lo && le_hi;
    assign valid_o[g] = v_q;
    assign off_o[g]   = off_q;
    assign prot_o[g]  = prot_q;
  end

  // R8: a clear leaves nothing valid
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_o == '0));

endmodule

// File: rtl/rtlb_alloc.sv
// Chooses where a new range goes: first empty slot, else round-robin victim.
module rtlb_alloc
  import rtlb_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 36,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_i,
  input  logic          req,
  input  logic [VW-1:0] req_base,
  input  logic [VW-1:0] req_limit,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output alloc_act_e    act
);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_found;
  logic          legal;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign legal = (req_limit >= req_base);

  always_comb begin
    if (!req)            act = ALLOC_IDLE;
    else if (!legal)     act = ALLOC_REJECT;
    else if (free_found) act = ALLOC_FILL;
    else                 act = ALLOC_EVICT;
  end

  assign wr_en  = (act == ALLOC_FILL) || (act == ALLOC_EVICT);
  assign wr_idx = free_found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (act == ALLOC_EVICT)
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
  end

  // R7: overwriting only ever happens on a full table
  a_r7_evict_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ALLOC_EVICT) |-> (&valid_i));

  // R7: pointer moves only when an overwrite took place
  a_r7_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ALLOC_EVICT) |=> $stable(rr_q));

endmodule

// File: rtl/rtlb_pick.sv
// Lowest-index match select and frame number synthesis.
module rtlb_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 36,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [VW-1:0] vpn_i,
  input  logic [N-1:0]  match_i,
  input  logic [VW-1:0] off_i  [N],
  input  logic [PW-1:0] prot_i [N],
  output logic          hit_o,
  output logic [N-1:0]  grant_o,
  output logic [VW-1:0] off_sel_o,
  output logic [VW-1:0] pfn_o,
  output logic [PW-1:0] prot_o
);

  logic [IW-1:0] win;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) win = IW'(i);
    end
  end

  assign hit_o = |match_i;

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign grant_o[g] = hit_o && (win == IW'(g));
  end

  assign off_sel_o = off_i[win];
  assign pfn_o     = hit_o ? (vpn_i + off_sel_o) : '0;
  assign prot_o    = hit_o ? prot_i[win] : '0;

endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import rtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = RTLB_ENTRIES,
  parameter int unsigned VPN_W   = RTLB_VPN_W,
  parameter int unsigned PROT_W  = RTLB_PROT_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [VPN_W-1:0]  lkp_vpn,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [VPN_W-1:0]  res_pfn,
  output logic [PROT_W-1:0] res_prot,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [VPN_W-1:0]  ins_base,
  input  logic [VPN_W-1:0]  ins_limit,
  input  logic [VPN_W-1:0]  ins_offset,
  input  logic [PROT_W-1:0] ins_prot,
  input  logic              inv_all
);

  logic               lkp_fire;
  logic               ins_fire;
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_match;
  logic [VPN_W-1:0]   ent_off  [ENTRIES];
  logic [PROT_W-1:0]  ent_prot [ENTRIES];
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  alloc_act_e         act;
  logic               hit;
  logic [ENTRIES-1:0] grant;
  logic [VPN_W-1:0]   off_sel;
  logic [VPN_W-1:0]   pfn;
  logic [PROT_W-1:0]  prot;

  assign lkp_ready = !res_valid || res_ready;
  assign ins_ready = !inv_all;
  assign lkp_fire  = lkp_valid && lkp_ready;
  assign ins_fire  = ins_valid && ins_ready;

  rtlb_store #(.N(ENTRIES), .VW(VPN_W), .PW(PROT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (inv_all),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_base   (ins_base),
    .wr_limit  (ins_limit),
    .wr_offset (ins_offset),
    .wr_prot   (ins_prot),
    .look_vpn  (lkp_vpn),
    .valid_o   (ent_valid),
    .match_o   (ent_match),
    .off_o     (ent_off),
    .prot_o    (ent_prot)
  );

  rtlb_alloc #(.N(ENTRIES), .VW(VPN_W)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (ent_valid),
    .req       (ins_fire),
    .req_base  (ins_base),
    .req_limit (ins_limit),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .act       (act)
  );

  rtlb_pick #(.N(ENTRIES), .VW(VPN_W), .PW(PROT_W)) u_pick (
    .vpn_i     (lkp_vpn),
    .match_i   (ent_match),
    .off_i     (ent_off),
    .prot_i    (ent_prot),
    .hit_o     (hit),
    .grant_o   (grant),
    .off_sel_o (off_sel),
    .pfn_o     (pfn),
    .prot_o    (prot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_prot  <= '0;
    end else if (lkp_fire) begin
      res_valid <= 1'b1;
      res_hit   <= hit;
      res_pfn   <= pfn;
      res_prot  <= prot;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9: a stalled result is held unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)
                                   && $stable(res_pfn) && $stable(res_prot)));

  // R9: every accepted lookup yields a result on the next edge
  a_r9_accept_result: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_fire |=> res_valid);

  // R4: at most one entry granted, and it is the lowest matching one
  a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r4_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((grant & ent_match) == grant) && (((grant - 1'b1) & ent_match) == '0)
             && (grant != '0)));

  // R3: frame number is page plus selected displacement
  a_r3_pfn_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_fire && hit) |=> (res_hit && (res_pfn == $past(lkp_vpn + off_sel))));

  // R5: a reversed range leaves occupancy untouched
  a_r5_reject_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && (ins_limit < ins_base)) |=> $stable(ent_valid));

  // R6: a legal insert into a non-full table adds exactly one entry
  a_r6_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && (ins_limit >= ins_base) && !(&ent_valid))
      |=> ($countones(ent_valid) == $countones($past(ent_valid)) + 1));

endmodule

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_valid, lkp_ready, res_valid, res_ready, res_hit;
  logic [35:0] lkp_vpn, res_pfn, ins_base, ins_limit, ins_offset;
  logic [3:0]  res_prot, ins_prot;
  logic        ins_valid, ins_ready, inv_all;

  always #2 clk = ~clk;

  range_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_vpn(lkp_vpn),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_pfn(res_pfn), .res_prot(res_prot),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_base(ins_base),
    .ins_limit(ins_limit), .ins_offset(ins_offset), .ins_prot(ins_prot),
    .inv_all(inv_all)
  );

  // behavioural reference state
  bit          mv [N];
  logic [35:0] mb [N], ml [N], mo [N];
  logic [3:0]  mp [N];
  int          rr;
  bit          e_valid, e_hit;
  logic [35:0] e_pfn;
  logic [3:0]  e_prot;

  int    n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit    done = 0;

  task automatic chk(input string what, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) mv[i] = 0;
    rr = 0; e_valid = 0; e_hit = 0; e_pfn = '0; e_prot = '0;
  endtask

  // one clock: drive, model, compare
  task automatic cyc(input bit lv, input logic [35:0] vpn, input bit rdy,
                     input bit iv, input logic [35:0] b, input logic [35:0] l,
                     input logic [35:0] o, input logic [3:0] p, input bit inv);
    bit lfire, ifire, nh;
    logic [35:0] npfn;
    logic [3:0]  nprot;
    int slot;
    @(negedge clk);
    lkp_valid = lv; lkp_vpn = vpn; res_ready = rdy;
    ins_valid = iv; ins_base = b; ins_limit = l; ins_offset = o; ins_prot = p;
    inv_all = inv;
    #1;
    chk("lkp_ready", 36'(lkp_ready), 36'(!e_valid || rdy));
    chk("ins_ready", 36'(ins_ready), 36'(!inv));
    lfire = lv && (!e_valid || rdy);
    ifire = iv && !inv;
    nh = 0; npfn = '0; nprot = '0;
    if (lfire) begin
      for (int i = 0; i < N; i++)
        if (!nh && mv[i] && vpn >= mb[i] && vpn <= ml[i]) begin
          nh = 1; npfn = vpn + mo[i]; nprot = mp[i];
        end
    end
    @(posedge clk); #1;
    if (lfire) begin e_valid = 1; e_hit = nh; e_pfn = npfn; e_prot = nprot; end
    else if (rdy) e_valid = 0;
    if (inv) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (ifire && l >= b) begin
      slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
      if (slot < 0) begin slot = rr; rr = (rr + 1) % N; end
      mv[slot] = 1; mb[slot] = b; ml[slot] = l; mo[slot] = o; mp[slot] = p;
    end
    chk("res_valid", 36'(res_valid), 36'(e_valid));
    if (e_valid) begin
      chk("res_hit", 36'(res_hit), 36'(e_hit));
      chk("res_pfn", res_pfn, e_pfn);
      chk("res_prot", 36'(res_prot), 36'(e_prot));
    end
  endtask

  task automatic look(input logic [35:0] vpn);
    cyc(1, vpn, 1, 0, '0, '0, '0, '0, 0);
  endtask

  task automatic put(input logic [35:0] b, input logic [35:0] l,
                     input logic [35:0] o, input logic [3:0] p);
    cyc(0, '0, 1, 1, b, l, o, p, 0);
  endtask

  task automatic clear();
    cyc(0, '0, 1, 0, '0, '0, '0, '0, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lkp_valid = 0; lkp_vpn = '0; res_ready = 1; ins_valid = 0;
    ins_base = '0; ins_limit = '0; ins_offset = '0; ins_prot = '0; inv_all = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: empty after reset
    req = "R1"; look(36'd10); look(36'd0);

    // R2 / R3: inclusive bounds, displacement and protection
    req = "R2"; put(36'd100, 36'd199, 36'd1000, 4'd3);
    look(36'd99); look(36'd100); look(36'd150); look(36'd199); look(36'd200);
    req = "R3"; put(36'hFFFFFFFF0, 36'hFFFFFFFFF, 36'h000000020, 4'd5);
    look(36'hFFFFFFFF8); look(36'hFFFFFFFFF);
    put(36'd1000, 36'd1100, -36'sd50, 4'd9);
    look(36'd1000); look(36'd1100);

    // R4 / R6: overlap, lowest-index slot wins
    req = "R4"; put(36'd150, 36'd300, 36'd5, 4'd7);
    look(36'd160); look(36'd250);
    req = "R6"; clear(); put(36'd150, 36'd300, 36'd5, 4'd7);
    put(36'd100, 36'd199, 36'd1000, 4'd3); look(36'd160); look(36'd120);

    // R5: reversed range changes nothing
    req = "R5"; put(36'd450, 36'd400, 36'd1, 4'd1); look(36'd420); look(36'd450);
    put(36'd140, 36'd145, 36'd2, 4'd2); look(36'd142);

    // R10: lookup alongside an insert sees the old table
    req = "R10"; cyc(1, 36'd500, 1, 1, 36'd490, 36'd510, 36'd3, 4'd4, 0);
    look(36'd500);

    // R9: back-pressure
    req = "R9"; cyc(1, 36'd495, 0, 0, '0, '0, '0, '0, 0);
    cyc(1, 36'd160, 0, 0, '0, '0, '0, '0, 0);
    cyc(1, 36'd120, 0, 0, '0, '0, '0, '0, 0);
    cyc(1, 36'd120, 1, 0, '0, '0, '0, '0, 0);
    cyc(0, '0, 1, 0, '0, '0, '0, '0, 0);

    // R8: clear with concurrent lookup and insert
    req = "R8"; cyc(1, 36'd495, 1, 1, 36'd600, 36'd700, 36'd1, 4'd1, 1);
    look(36'd495); look(36'd650); look(36'd160);

    // R7: fill all slots, then overwrite round-robin
    req = "R7";
    for (int i = 0; i < N; i++)
      put(36'(i * 64), 36'(i * 64 + 31), 36'(i * 4096), 4'(i));
    for (int i = 0; i < N; i++) look(36'(i * 64 + 5));
    for (int i = 0; i < 3; i++) put(36'(5000 + i * 10), 36'(5005 + i * 10), 36'd7, 4'd15);
    for (int i = 0; i < 5; i++) look(36'(i * 64 + 31));
    for (int i = 0; i < 3; i++) look(36'(5003 + i * 10));
    clear(); put(36'd1, 36'd2, 36'd3, 4'd4); look(36'd2);

    // mixed traffic
    req = "R2";
    for (int k = 0; k < 3000; k++) begin
      logic [35:0] b;
      b = 36'($urandom_range(0, 2000));
      cyc($urandom_range(0, 3) != 0, 36'($urandom_range(0, 2100)),
          $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, b,
          ($urandom_range(0, 9) == 0) ? b - 36'd1 : b + 36'($urandom_range(0, 60)),
          36'($urandom) - 36'($urandom_range(0, 3000)), 4'($urandom),
          $urandom_range(0, 199) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule